// File: doc/BRIEF.md
# DMA Ring Queue Pointer Manager

This block tracks the read and write positions of a small set of DMA command rings that software maps and unmaps at run time. A registration request claims the lowest-numbered free slot. It supplies a doorbell offset, a base field, a control word whose size field gives the ring length, and a 64-bit host address split into two 32-bit halves. For each slot the block keeps a read pointer that wraps at the ring end, a write pointer that is also kept inside the ring, and a second read pointer that never wraps. The second pointer is the running byte count that the host driver expects to see.

A doorbell write updates a ring's write pointer and marks the ring busy. The packet consumer then moves the read pointer forward, either by advance pulses or by direct loads. When the consumer reports the end of a processing burst, the block queues one write of the unwrapped read pointer to the ring's host address, unless that address is zero, and clears the busy flag. Writes leave through a valid/ready port. A select input shows the full state of any one slot.

Top module: `ring_ptr_mgr`

## Requirements
- R1: The ring size in bytes is 4 shifted left by ctrl bits [6:1]. The wrap mask reported for a slot is the size minus one, and it saturates to all ones once the size reaches the full pointer width.
- R2: The stored ring base is the base field shifted left by 8. The slot key is the doorbell offset shifted left by 2. The host write-back address is the high word concatenated above the low word.
- R3: A registration goes to slot 0 if slot 0 is free, and otherwise to slot 1.
- R4: A registration that arrives when every slot is valid raises reg_err_o for exactly one cycle, starting the cycle after the request, and leaves every slot unchanged.
- R5: A registration sets the slot valid and clears its wrapped read pointer, its write pointer, its absolute read pointer and its busy flag.
- R6: An advance by N sets the wrapped read pointer to (rptr + N) AND mask, and adds N to the absolute read pointer without any wrap.
- R7: A direct load of value V sets the absolute read pointer to V and the wrapped read pointer to V AND mask. A load takes priority over an advance to the same slot in the same cycle.
- R8: A doorbell whose key matches a valid slot stores the write pointer AND mask and sets that slot busy. A doorbell whose key matches no slot changes nothing.
- R9: A burst end on a valid slot clears its busy flag. If the slot's write-back address is non-zero, the block issues exactly one write carrying the absolute read pointer to that address. If the address is zero, no write is issued.
- R10: While wb_valid_o is high and wb_ready_i is low, wb_valid_o, wb_addr_o and wb_data_o hold their values.
- R11: An unregister request clears the valid bit of the slot whose key matches, so that the next registration can reuse the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Registration request |
| reg_doorbell_i | input | DB_W | Doorbell offset |
| reg_base_i | input | BASE_W | Ring base field |
| reg_ctrl_i | input | 32 | Control word; bits [6:1] select the size |
| reg_wb_lo_i | input | 32 | Write-back address, low word |
| reg_wb_hi_i | input | 32 | Write-back address, high word |
| reg_err_o | output | 1 | Registration refused, all slots in use |
| unreg_valid_i | input | 1 | Unregister request |
| unreg_key_i | input | KEY_W | Key of the slot to free |
| db_valid_i | input | 1 | Doorbell write |
| db_key_i | input | KEY_W | Doorbell key |
| db_wptr_i | input | PTR_W | New write pointer |
| adv_valid_i | input | 1 | Read pointer advance |
| adv_slot_i | input | SLOT_W | Slot to advance |
| adv_bytes_i | input | PTR_W | Advance amount in bytes |
| load_valid_i | input | 1 | Direct read pointer load |
| load_slot_i | input | SLOT_W | Slot to load |
| load_value_i | input | PTR_W | Loaded value |
| done_valid_i | input | 1 | End of a processing burst |
| done_slot_i | input | SLOT_W | Slot whose burst ended |
| q_sel_i | input | SLOT_W | Slot shown on the q_* outputs |
| q_valid_o | output | 1 | Slot valid |
| q_key_o | output | KEY_W | Slot key |
| q_base_o | output | ADDR_W | Ring base address |
| q_mask_o | output | PTR_W | Ring wrap mask |
| q_rptr_o | output | PTR_W | Wrapped read pointer |
| q_wptr_o | output | PTR_W | Write pointer |
| q_abs_rptr_o | output | ABS_W | Absolute read pointer |
| q_busy_o | output | 1 | Burst in progress |
| wb_valid_o | output | 1 | Write-back request |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_addr_o | output | ADDR_W | Write-back address |
| wb_data_o | output | ABS_W | Absolute read pointer to write |

## Verification
The bench advances a ring past its end several times, including an advance of exactly one full ring. The check is that the wrapped pointer folds back while the absolute pointer keeps counting; a design that wrapped both would post a small stale value that stalls the host. It fills both slots and then registers once more, and it frees a slot and registers again. These steps catch a wrong search order, a refusal that still overwrites a slot, and a freed slot that is never reused. It also checks a ring with a zero write-back address, which must post nothing, and a ring with a saturated size field, where the 32-bit pointer wraps at its own width but the 64-bit count carries past it. Finally it holds the write port stalled, which exposes a request that changes or drops before it is accepted.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int unsigned CTRL_W      = 32;
  localparam int unsigned SEL_LSB     = 1;
  localparam int unsigned SEL_W       = 6;
  localparam int unsigned BASE_SHIFT  = 8;
  localparam int unsigned KEY_SHIFT   = 2;
  localparam int unsigned UNIT_LOG2   = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADV  = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] oh_o,
  output logic         any_o
);
  always_comb begin
    oh_o  = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        oh_o[i] = 1'b1;
        any_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_slot.sv
module ring_slot
  import ring_ptr_pkg::*;
#(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned ABS_W  = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned KEY_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [KEY_W-1:0]  alloc_key_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  input  logic [SEL_W-1:0]  alloc_sel_i,
  input  logic [ADDR_W-1:0] alloc_wb_i,
  input  logic              unreg_i,
  input  logic              db_i,
  input  logic [PTR_W-1:0]  db_wptr_i,
  input  ptr_op_e           op_i,
  input  logic [PTR_W-1:0]  op_val_i,
  input  logic              done_i,
  input  logic              grant_i,
  output logic              valid_o,
  output logic [KEY_W-1:0]  key_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  mask_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [ABS_W-1:0]  abs_o,
  output logic              busy_o,
  output logic              pend_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [ABS_W-1:0]  snap_o
);
  logic              valid_q, busy_q, pend_q;
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] base_q, wb_q;
  logic [PTR_W-1:0]  mask_q, rptr_q, wptr_q, rptr_d;
  logic [ABS_W-1:0]  abs_q, abs_d, snap_q;
  logic              post_wb;

  // size = 4 << sel; mask saturates when size reaches 2^PTR_W
  function automatic logic [PTR_W-1:0] sel_to_mask(input logic [SEL_W-1:0] s);
    if (int'(s) >= int'(PTR_W - UNIT_LOG2)) return '1;
    return (PTR_W'(1) << (int'(s) + UNIT_LOG2)) - PTR_W'(1);
  endfunction

  always_comb begin
    rptr_d = rptr_q;
    abs_d  = abs_q;
    if (valid_q) begin
      unique case (op_i)
        OP_LOAD: begin
          rptr_d = op_val_i & mask_q;
          abs_d  = ABS_W'(op_val_i);
        end
        OP_ADV: begin
          rptr_d = (rptr_q + op_val_i) & mask_q;
          abs_d  = abs_q + ABS_W'(op_val_i);
        end
        default: ;
      endcase
    end
  end

  assign post_wb = valid_q && done_i && (wb_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      key_q   <= '0;
      base_q  <= '0;
      wb_q    <= '0;
      mask_q  <= '0;
      rptr_q  <= '0;
      wptr_q  <= '0;
      abs_q   <= '0;
      snap_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      key_q   <= alloc_key_i;
      base_q  <= alloc_base_i;
      wb_q    <= alloc_wb_i;
      mask_q  <= sel_to_mask(alloc_sel_i);
      rptr_q  <= '0;
      wptr_q  <= '0;
      abs_q   <= '0;
    end else begin
      rptr_q <= rptr_d;
      abs_q  <= abs_d;
      if (valid_q && db_i) begin
        wptr_q <= db_wptr_i & mask_q;
        busy_q <= 1'b1;
      end
      if (valid_q && done_i) busy_q <= 1'b0;
      if (grant_i) pend_q <= 1'b0;
      if (post_wb) begin
        pend_q <= 1'b1;
        snap_q <= abs_d;
      end
      if (unreg_i) begin
        valid_q <= 1'b0;
        busy_q  <= 1'b0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign key_o     = key_q;
  assign base_o    = base_q;
  assign mask_o    = mask_q;
  assign rptr_o    = rptr_q;
  assign wptr_o    = wptr_q;
  assign abs_o     = abs_q;
  assign busy_o    = busy_q;
  assign pend_o    = pend_q;
  assign wb_addr_o = wb_q;
  assign snap_o    = snap_q;

  p_rptr_in_ring_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rptr_q & ~mask_q) == '0);
  p_reg_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> valid_q && !busy_q && rptr_q == '0 && wptr_q == '0 && abs_q == '0);
  p_abs_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !alloc_i && op_i == OP_ADV) |=> abs_q == $past(abs_q) + ABS_W'($past(op_val_i)));
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && done_i && !alloc_i && !db_i) |=> !busy_q);
endmodule

// File: rtl/wb_issuer.sv
module wb_issuer #(
  parameter int unsigned N      = 2,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ABS_W  = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N-1:0]                pend_i,
  input  logic [N-1:0][ADDR_W-1:0]    addr_i,
  input  logic [N-1:0][ABS_W-1:0]     data_i,
  output logic [N-1:0]                grant_o,
  output logic                        wb_valid_o,
  input  logic                        wb_ready_i,
  output logic [ADDR_W-1:0]           wb_addr_o,
  output logic [ABS_W-1:0]            wb_data_o
);
  logic [N-1:0]      pick_oh;
  logic              pick_any, take;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q, addr_sel;
  logic [ABS_W-1:0]  data_q, data_sel;

  lowest_pick #(.N(N)) i_pick (.req_i(pend_i), .oh_o(pick_oh), .any_o(pick_any));

  always_comb begin
    addr_sel = '0;
    data_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_oh[i]) begin
        addr_sel = addr_sel | addr_i[i];
        data_sel = data_sel | data_i[i];
      end
    end
  end

  assign take    = !valid_q || wb_ready_i;
  assign grant_o = take ? pick_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= pick_any;
      if (pick_any) begin
        addr_q <= addr_sel;
        data_q <= data_sel;
      end
    end
  end

  assign wb_valid_o = valid_q;
  assign wb_addr_o  = addr_q;
  assign wb_data_o  = data_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o));
  p_nonzero_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_addr_o != '0);
  p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_ptr_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned PTR_W     = 32,
  parameter int unsigned ABS_W     = 64,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DB_W      = 16,
  parameter int unsigned BASE_W    = 40,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned KEY_W    = DB_W + KEY_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic [DB_W-1:0]   reg_doorbell_i,
  input  logic [BASE_W-1:0] reg_base_i,
  input  logic [CTRL_W-1:0] reg_ctrl_i,
  input  logic [31:0]       reg_wb_lo_i,
  input  logic [31:0]       reg_wb_hi_i,
  output logic              reg_err_o,
  input  logic              unreg_valid_i,
  input  logic [KEY_W-1:0]  unreg_key_i,
  input  logic              db_valid_i,
  input  logic [KEY_W-1:0]  db_key_i,
  input  logic [PTR_W-1:0]  db_wptr_i,
  input  logic              adv_valid_i,
  input  logic [SLOT_W-1:0] adv_slot_i,
  input  logic [PTR_W-1:0]  adv_bytes_i,
  input  logic              load_valid_i,
  input  logic [SLOT_W-1:0] load_slot_i,
  input  logic [PTR_W-1:0]  load_value_i,
  input  logic              done_valid_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  input  logic [SLOT_W-1:0] q_sel_i,
  output logic              q_valid_o,
  output logic [KEY_W-1:0]  q_key_o,
  output logic [ADDR_W-1:0] q_base_o,
  output logic [PTR_W-1:0]  q_mask_o,
  output logic [PTR_W-1:0]  q_rptr_o,
  output logic [PTR_W-1:0]  q_wptr_o,
  output logic [ABS_W-1:0]  q_abs_rptr_o,
  output logic              q_busy_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [ABS_W-1:0]  wb_data_o
);
  logic [NUM_SLOTS-1:0]             s_valid, s_busy, s_pend, grant;
  logic [NUM_SLOTS-1:0]             free_oh, db_hit, db_oh, un_hit, un_oh;
  logic                             any_free, db_any, un_any;
  logic [NUM_SLOTS-1:0][KEY_W-1:0]  s_key;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] s_base, s_wb;
  logic [NUM_SLOTS-1:0][PTR_W-1:0]  s_mask, s_rptr, s_wptr;
  logic [NUM_SLOTS-1:0][ABS_W-1:0]  s_abs, s_snap;

  logic [KEY_W-1:0]  new_key;
  logic [ADDR_W-1:0] new_base, new_wb;
  logic [SEL_W-1:0]  new_sel;
  logic              reg_err_q;
  logic              unused_ctrl, unused_any;

  assign new_key     = {reg_doorbell_i, KEY_SHIFT'(0)};
  assign new_base    = ADDR_W'(reg_base_i) << BASE_SHIFT;
  assign new_wb      = ADDR_W'({reg_wb_hi_i, reg_wb_lo_i});
  assign new_sel     = reg_ctrl_i[SEL_LSB +: SEL_W];
  assign unused_ctrl = ^{reg_ctrl_i[CTRL_W-1:SEL_LSB+SEL_W], reg_ctrl_i[SEL_LSB-1:0]};
  assign unused_any  = db_any ^ un_any;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      db_hit[i] = s_valid[i] && (s_key[i] == db_key_i) && db_valid_i;
      un_hit[i] = s_valid[i] && (s_key[i] == unreg_key_i) && unreg_valid_i;
    end
  end

  lowest_pick #(.N(NUM_SLOTS)) i_free_pick (.req_i(~s_valid), .oh_o(free_oh), .any_o(any_free));
  lowest_pick #(.N(NUM_SLOTS)) i_db_pick   (.req_i(db_hit),   .oh_o(db_oh),   .any_o(db_any));
  lowest_pick #(.N(NUM_SLOTS)) i_un_pick   (.req_i(un_hit),   .oh_o(un_oh),   .any_o(un_any));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic    ld_hit, ad_hit;
    ptr_op_e op;
    logic [PTR_W-1:0] op_val;

    assign ld_hit = load_valid_i && (int'(load_slot_i) == g);
    assign ad_hit = adv_valid_i  && (int'(adv_slot_i)  == g);
    assign op     = ld_hit ? OP_LOAD : (ad_hit ? OP_ADV : OP_NONE);
    assign op_val = ld_hit ? load_value_i : adv_bytes_i;

    ring_slot #(
      .PTR_W(PTR_W), .ABS_W(ABS_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W)
    ) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (reg_valid_i && free_oh[g]),
      .alloc_key_i (new_key),
      .alloc_base_i(new_base),
      .alloc_sel_i (new_sel),
      .alloc_wb_i  (new_wb),
      .unreg_i     (un_oh[g]),
      .db_i        (db_oh[g]),
      .db_wptr_i   (db_wptr_i),
      .op_i        (op),
      .op_val_i    (op_val),
      .done_i      (done_valid_i && (int'(done_slot_i) == g)),
      .grant_i     (grant[g]),
      .valid_o     (s_valid[g]),
      .key_o       (s_key[g]),
      .base_o      (s_base[g]),
      .mask_o      (s_mask[g]),
      .rptr_o      (s_rptr[g]),
      .wptr_o      (s_wptr[g]),
      .abs_o       (s_abs[g]),
      .busy_o      (s_busy[g]),
      .pend_o      (s_pend[g]),
      .wb_addr_o   (s_wb[g]),
      .snap_o      (s_snap[g])
    );
  end

  wb_issuer #(.N(NUM_SLOTS), .ADDR_W(ADDR_W), .ABS_W(ABS_W)) i_issuer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (s_pend),
    .addr_i    (s_wb),
    .data_i    (s_snap),
    .grant_o   (grant),
    .wb_valid_o(wb_valid_o),
    .wb_ready_i(wb_ready_i),
    .wb_addr_o (wb_addr_o),
    .wb_data_o (wb_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_err_q <= 1'b0;
    else         reg_err_q <= reg_valid_i && !any_free;
  end
  assign reg_err_o = reg_err_q;

  always_comb begin
    q_valid_o    = 1'b0;
    q_key_o      = '0;
    q_base_o     = '0;
    q_mask_o     = '0;
    q_rptr_o     = '0;
    q_wptr_o     = '0;
    q_abs_rptr_o = '0;
    q_busy_o     = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(q_sel_i) == i) begin
        q_valid_o    = s_valid[i];
        q_key_o      = s_key[i];
        q_base_o     = s_base[i];
        q_mask_o     = s_mask[i];
        q_rptr_o     = s_rptr[i];
        q_wptr_o     = s_wptr[i];
        q_abs_rptr_o = s_abs[i];
        q_busy_o     = s_busy[i];
      end
    end
  end

  p_err_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && (&s_valid)) |=> reg_err_o);
  p_err_only_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !(&s_valid)) |=> !reg_err_o);
  p_full_keeps_keys_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && (&s_valid) && !unreg_valid_i) |=> $stable(s_key) && $stable(s_base));
  p_slot0_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !s_valid[0]) |=> s_valid[0] && s_key[0] == $past(new_key));
endmodule

// File: tb/test_ring_ptr_mgr.sv
module test_ring_ptr_mgr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 0;
  logic [15:0] reg_db = '0;
  logic [39:0] reg_base = '0;
  logic [31:0] reg_ctrl = '0, reg_lo = '0, reg_hi = '0;
  logic        reg_err;
  logic        un_valid = 0;
  logic [17:0] un_key = '0;
  logic        db_valid = 0;
  logic [17:0] db_key = '0;
  logic [31:0] db_wptr = '0;
  logic        adv_valid = 0;
  logic        adv_slot = 0;
  logic [31:0] adv_bytes = '0;
  logic        ld_valid = 0;
  logic        ld_slot = 0;
  logic [31:0] ld_value = '0;
  logic        done_valid = 0;
  logic        done_slot = 0;
  logic        q_sel = 0;
  logic        q_valid, q_busy;
  logic [17:0] q_key;
  logic [63:0] q_base, q_abs, wb_addr, wb_data;
  logic [31:0] q_mask, q_rptr, q_wptr;
  logic        wb_valid;
  logic        wb_ready = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [127:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_ptr_mgr i_ring_ptr_mgr (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_doorbell_i(reg_db), .reg_base_i(reg_base),
    .reg_ctrl_i(reg_ctrl), .reg_wb_lo_i(reg_lo), .reg_wb_hi_i(reg_hi), .reg_err_o(reg_err),
    .unreg_valid_i(un_valid), .unreg_key_i(un_key),
    .db_valid_i(db_valid), .db_key_i(db_key), .db_wptr_i(db_wptr),
    .adv_valid_i(adv_valid), .adv_slot_i(adv_slot), .adv_bytes_i(adv_bytes),
    .load_valid_i(ld_valid), .load_slot_i(ld_slot), .load_value_i(ld_value),
    .done_valid_i(done_valid), .done_slot_i(done_slot),
    .q_sel_i(q_sel), .q_valid_o(q_valid), .q_key_o(q_key), .q_base_o(q_base),
    .q_mask_o(q_mask), .q_rptr_o(q_rptr), .q_wptr_o(q_wptr), .q_abs_rptr_o(q_abs),
    .q_busy_o(q_busy),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each accepted write-back
  always @(negedge clk) begin
    if (rst_n && wb_valid && wb_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: actual unexpected write %0h/%0h expected none", wb_addr, wb_data);
      end else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        if ({wb_addr, wb_data} !== e) begin
          n_bad++;
          $display("FAIL R9: actual %0h expected %0h", {wb_addr, wb_data}, e);
        end
      end
    end
  end

  task automatic do_reg(input logic [15:0] d, input logic [39:0] b, input logic [31:0] c,
                        input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    reg_valid = 1; reg_db = d; reg_base = b; reg_ctrl = c; reg_hi = hi; reg_lo = lo;
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic do_unreg(input logic [17:0] k);
    @(negedge clk); un_valid = 1; un_key = k;
    @(negedge clk); un_valid = 0;
  endtask

  task automatic do_db(input logic [17:0] k, input logic [31:0] w);
    @(negedge clk); db_valid = 1; db_key = k; db_wptr = w;
    @(negedge clk); db_valid = 0;
  endtask

  task automatic do_adv(input logic s, input logic [31:0] n);
    @(negedge clk); adv_valid = 1; adv_slot = s; adv_bytes = n;
    @(negedge clk); adv_valid = 0;
  endtask

  task automatic do_load(input logic s, input logic [31:0] v);
    @(negedge clk); ld_valid = 1; ld_slot = s; ld_value = v;
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic do_done(input logic s, input bit expect_wb, input logic [63:0] a, input logic [63:0] d);
    if (expect_wb) exp_q.push_back({a, d});
    @(negedge clk); done_valid = 1; done_slot = s;
    @(negedge clk); done_valid = 0;
  endtask

  task automatic peek(input logic s);
    q_sel = s;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    peek(0); check("R5 reset slot0 valid", q_valid, 0);
    peek(1); check("R5 reset slot1 valid", q_valid, 0);
    check("R10 reset wb_valid", wb_valid, 0);
    check("R4 reset err", reg_err, 0);

    // R3 R2 R1: first registration lands in slot 0
    do_reg(16'h10, 40'h1234, 32'h8, 32'h1, 32'h8000);
    check("R4 no err when free", reg_err, 0);
    peek(0);
    check("R3 slot0 valid", q_valid, 1);
    check("R2 key", q_key, 18'h40);
    check("R2 base", q_base, 64'h123400);
    check("R1 mask sel4", q_mask, 32'd63);
    check("R5 rptr clear", q_rptr, 0);
    check("R5 abs clear", q_abs, 0);
    check("R5 busy clear", q_busy, 0);

    // second goes to slot 1; ctrl bits outside [6:1] ignored
    do_reg(16'h20, 40'h55, 32'h85, 32'h0, 32'h0);
    peek(1);
    check("R3 slot1 valid", q_valid, 1);
    check("R2 key slot1", q_key, 18'h80);
    check("R2 base slot1", q_base, 64'h5500);
    check("R1 mask sel2", q_mask, 32'd15);

    // full: error pulse, nothing changes
    do_reg(16'h30, 40'h99, 32'h2, 32'h0, 32'h4);
    check("R4 err raised", reg_err, 1);
    peek(0); check("R4 slot0 key kept", q_key, 18'h40);
    check("R4 slot0 base kept", q_base, 64'h123400);
    peek(1); check("R4 slot1 key kept", q_key, 18'h80);
    @(negedge clk);
    check("R4 err one cycle", reg_err, 0);

    // R8 doorbells
    do_db(18'h40, 32'd100);
    peek(0);
    check("R8 wptr masked", q_wptr, 32'd36);
    check("R8 busy set", q_busy, 1);
    do_db(18'h44, 32'd5);
    peek(0); check("R8 unmatched ignored slot0", q_wptr, 32'd36);
    peek(1); check("R8 unmatched ignored slot1", q_wptr, 32'd0);
    check("R8 unmatched no busy", q_busy, 0);

    // R6 advances across the ring end
    do_adv(0, 32'd40);
    peek(0); check("R6 rptr 40", q_rptr, 32'd40); check("R6 abs 40", q_abs, 64'd40);
    do_adv(0, 32'd40);
    peek(0); check("R6 rptr wrap", q_rptr, 32'd16); check("R6 abs 80", q_abs, 64'd80);
    do_adv(0, 32'd64);
    peek(0); check("R6 rptr full ring", q_rptr, 32'd16); check("R6 abs 144", q_abs, 64'd144);

    // R9 write-back on burst end
    do_done(0, 1, 64'h1_0000_8000, 64'd144);
    peek(0); check("R9 busy cleared", q_busy, 0);
    repeat (3) @(negedge clk);

    // R7 load on slot1, then advance, then burst end without address
    do_load(1, 32'h23);
    peek(1); check("R7 rptr masked", q_rptr, 32'd3); check("R7 abs loaded", q_abs, 64'h23);
    do_adv(1, 32'd20);
    peek(1); check("R6 rptr slot1", q_rptr, 32'd7); check("R6 abs slot1", q_abs, 64'h37);
    do_db(18'h80, 32'd17);
    peek(1); check("R8 wptr slot1", q_wptr, 32'd1); check("R8 busy slot1", q_busy, 1);
    do_done(1, 0, '0, '0);
    peek(1); check("R9 busy cleared slot1", q_busy, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 no write for zero address", wb_valid, 0);
    end

    // R10 backpressure
    wb_ready = 0;
    do_done(0, 1, 64'h1_0000_8000, 64'd144);
    repeat (3) @(negedge clk);
    check("R10 valid held", wb_valid, 1);
    check("R10 addr held", wb_addr, 64'h1_0000_8000);
    repeat (2) @(negedge clk);
    check("R10 data held", wb_data, 64'd144);
    check("R10 still valid", wb_valid, 1);
    wb_ready = 1;
    repeat (3) @(negedge clk);
    check("R10 released", wb_valid, 0);

    // R11 unregister and reuse slot 0
    do_unreg(18'h40);
    peek(0); check("R11 slot0 freed", q_valid, 0);
    peek(1); check("R11 slot1 untouched", q_valid, 1);
    do_reg(16'h30, 40'h1, 32'h0, 32'h0, 32'h40);
    check("R4 no err after free", reg_err, 0);
    peek(0);
    check("R11 slot0 reused", q_key, 18'hC0);
    check("R1 mask sel0", q_mask, 32'd3);
    check("R5 abs cleared on reuse", q_abs, 0);
    check("R5 rptr cleared on reuse", q_rptr, 0);
    do_adv(0, 32'd7);
    peek(0); check("R6 small ring rptr", q_rptr, 32'd3); check("R6 small ring abs", q_abs, 64'd7);
    do_done(0, 1, 64'h40, 64'd7);
    repeat (3) @(negedge clk);

    // saturated size field: 32-bit wrap, 64-bit count
    do_unreg(18'h80);
    do_reg(16'h7, 40'h2, 32'h50, 32'hABCD, 32'h10);
    peek(1);
    check("R11 slot1 reused", q_key, 18'h1C);
    check("R1 mask saturated", q_mask, 32'hFFFF_FFFF);
    do_adv(1, 32'hFFFF_FFF0);
    do_adv(1, 32'hFFFF_FFF0);
    peek(1);
    check("R6 rptr native wrap", q_rptr, 32'hFFFF_FFE0);
    check("R6 abs carries", q_abs, 64'h1_FFFF_FFE0);
    do_done(1, 1, 64'hABCD_0000_0010, 64'h1_FFFF_FFE0);
    repeat (5) @(negedge clk);

    check("R9 all expected writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule